// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block guards a system against stuck or runaway software. A 7-bit down-counter decrements on a tick made by dividing the peripheral bus clock. Software must rewrite the counter ("refresh") regularly. If it waits too long, the counter falls from 0x40 to 0x3F and the block requests a system reset. If it refreshes too early, the block also requests a reset. Too early means while the counter is still above a programmed window value. One count before the timeout, at 0x40, a warning flag rises so that software gets a last chance to act. An optional interrupt follows the flag.

Software drives the block through a small write port with three registers. The control register (address 0) holds the counter load value in bits [6:0] and the start bit in bit 7. The configuration register (address 1) holds:
- the window value in bits [6:0];
- the prescaler select in bits [8:7];
- the interrupt enable in bit 9;
- the debug-stop option in bit 10.

The status register (address 2) clears the flag. Address 3 is unused. A debug-halt input can freeze the counter while a debugger holds the core.

A small state machine sets the activity of the block. It has three states:
- **OFF** (not started).
- **RUN** (counting).
- **HALT** (frozen by debug).

It has three transitions:
- **START** takes OFF to RUN when a control write has bit 7 set.
- **FREEZE** takes RUN to HALT while debug-halt is high and debug-stop is set.
- **RESUME** takes HALT back to RUN once that condition ends.

The machine never returns to OFF except through reset.

Top module: `win_watchdog`

## Requirements
- R1: After reset the counter reads 0x7F, and the warning flag, interrupt and reset request are all low. The block is in OFF.
- R2: A control write with bit 7 = 1 starts the watchdog (START) and loads bits [6:0]. Later control writes with bit 7 = 0 never stop it. In OFF, control writes only load the counter, which then holds its value.
- R3: In RUN the counter decrements once every BASE_DIV × 2^sel clock cycles, where sel is configuration bits [8:7]. Every control write restarts the prescaler phase, so the first decrement lands exactly one period after the write edge.
- R4: The decrement from 0x40 to 0x3F raises the reset request for exactly one clock cycle. That cycle follows the decrementing edge.
- R5: The warning flag is set by the decrement that reaches 0x40. The interrupt output equals the flag AND the interrupt enable (configuration bit 9).
- R6: A control write while running and while the counter is greater than the window (configuration bits [6:0]) raises a one-cycle reset request and sets the warning flag. If the counter is at or below the window, the write raises neither.
- R7: A control write that leaves the watchdog running but has bit 6 = 0 raises a one-cycle reset request.
- R8: While in OFF no reset request is ever raised, even for a control write with bit 6 = 0 and bit 7 = 0.
- R9: A status write with bit 0 = 0 clears the warning flag. A status write with bit 0 = 1 leaves it unchanged. A flag set in the same cycle wins over the clear.
- R10: With debug-stop (configuration bit 10) set, debug-halt high moves RUN to HALT (FREEZE). In HALT the counter and prescaler phase hold; RESUME continues from the held phase. With debug-stop clear, the counter keeps counting under debug-halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral bus clock |
| rst_ni | input | 1 | Active-low synchronous system reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 configuration, 2 status |
| wr_data_i | input | CNT_W+4 | Write data |
| dbg_halt_i | input | 1 | Debugger holds the core |
| cnt_o | output | CNT_W | Current counter value |
| warn_o | output | 1 | Early-warning flag |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A wrong prescaler phase or limit shows at `cnt_o` within one period: the first decrement after a refresh lands a cycle early or late. A corrupted comparison against the window or against 0x40 shows in the same cycle as the offending write or tick, as a missing or extra pulse on `rst_req_o` and a wrong `warn_o`. A state machine stuck in or wrongly entering HALT or OFF shows as a frozen or running `cnt_o` within a few ticks after the debug input or start write changes.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
    typedef enum logic [1:0] {
        WST_OFF  = 2'd0,
        WST_RUN  = 2'd1,
        WST_HALT = 2'd2
    } wwd_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
    parameter int BASE_DIV = 4096,
    parameter int SEL_W    = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
    localparam int PW      = $clog2(MAX_DIV);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit  = PW'((BASE_DIV << sel_i) - 1);
        tick_o = run_i && !restart_i && (phase_q == limit);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else if (restart_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            if (phase_q == limit) phase_q <= '0;
            else                  phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/wwd_fsm.sv
module wwd_fsm
    import wwd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic       freeze_i,
    output wwd_state_e state_o,
    output logic       run_o,
    output logic       active_o
);
    wwd_state_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= WST_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WST_OFF:  if (start_i)   state_d = WST_RUN;   // START
            WST_RUN:  if (freeze_i)  state_d = WST_HALT;  // FREEZE
            WST_HALT: if (!freeze_i) state_d = WST_RUN;   // RESUME
            default:                 state_d = WST_OFF;
        endcase
    end

    always_comb begin
        state_o  = state_q;
        run_o    = (state_q == WST_RUN);
        active_o = (state_q != WST_OFF);
    end
endmodule

// File: rtl/wwd_counter.sv
module wwd_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             armed_i,
    input  logic             live_i,
    input  logic [CNT_W-1:0] window_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             warn_o,
    output logic             rst_req_o
);
    localparam logic [CNT_W-1:0] WARN_VAL = CNT_W'(1) << (CNT_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             warn_q, req_q;
    logic             too_early, bad_msb, expire, reach;

    always_comb begin
        too_early = load_i && live_i && (cnt_q > window_i);
        bad_msb   = load_i && armed_i && !load_val_i[CNT_W-1];
        expire    = tick_i && !load_i && (cnt_q == WARN_VAL);
        reach     = tick_i && !load_i && (cnt_q == WARN_VAL + CNT_W'(1));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '1;
            warn_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            if (load_i)      cnt_q <= load_val_i;
            else if (tick_i) cnt_q <= cnt_q - 1'b1;

            if (reach || too_early) warn_q <= 1'b1;
            else if (clr_i)         warn_q <= 1'b0;

            req_q <= too_early || bad_msb || expire;
        end
    end

    assign cnt_o     = cnt_q;
    assign warn_o    = warn_q;
    assign rst_req_o = req_q;
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wwd_pkg::*;
#(
    parameter int BASE_DIV = 4096,
    parameter int CNT_W    = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W+3:0] wr_data_i,
    input  logic             dbg_halt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             warn_o,
    output logic             irq_o,
    output logic             rst_req_o
);
    localparam int SEL_W = 2;

    logic [CNT_W-1:0] window_q;
    logic [SEL_W-1:0] sel_q;
    logic             irq_en_q, dbg_stop_q;

    logic       ctrl_wr, cfg_wr, clr, start, armed, freeze;
    logic       run, active, tick;
    wwd_state_e state;

    always_comb begin
        ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
        cfg_wr  = wr_en_i && (wr_addr_i == A_CFG);
        clr     = wr_en_i && (wr_addr_i == A_STAT) && !wr_data_i[0];
        start   = ctrl_wr && wr_data_i[CNT_W] && !active;
        armed   = active || (ctrl_wr && wr_data_i[CNT_W]);
        freeze  = dbg_halt_i && dbg_stop_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            window_q   <= '1;
            sel_q      <= '0;
            irq_en_q   <= 1'b0;
            dbg_stop_q <= 1'b0;
        end else if (cfg_wr) begin
            window_q   <= wr_data_i[CNT_W-1:0];
            sel_q      <= wr_data_i[CNT_W+1:CNT_W];
            irq_en_q   <= wr_data_i[CNT_W+2];
            dbg_stop_q <= wr_data_i[CNT_W+3];
        end
    end

    wwd_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .freeze_i (freeze),
        .state_o  (state),
        .run_o    (run),
        .active_o (active)
    );

    wwd_prescaler #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W)) u_psc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .restart_i (ctrl_wr),
        .sel_i     (sel_q),
        .tick_o    (tick)
    );

    wwd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .load_i     (ctrl_wr),
        .load_val_i (wr_data_i[CNT_W-1:0]),
        .armed_i    (armed),
        .live_i     (active),
        .window_i   (window_q),
        .clr_i      (clr),
        .cnt_o      (cnt_o),
        .warn_o     (warn_o),
        .rst_req_o  (rst_req_o)
    );

    assign irq_o = warn_o && irq_en_q;
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker
    import wwd_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input logic             clk_i,
    input logic             rst_ni,
    input wwd_state_e       state,
    input logic             tick,
    input logic             ctrl_wr,
    input logic             start,
    input logic [CNT_W-1:0] cnt_o,
    input logic             warn_o,
    input logic             rst_req_o
);
    localparam logic [CNT_W-1:0] WARN_VAL = CNT_W'(1) << (CNT_W - 1);

    p_sticky_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state != WST_OFF) |=> (state != WST_OFF));

    p_off_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == WST_OFF && !ctrl_wr) |=> $stable(cnt_o));

    p_timeout_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && !ctrl_wr && cnt_o == WARN_VAL) |=> rst_req_o);

    p_warn_on_reach_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && !ctrl_wr && cnt_o == WARN_VAL + CNT_W'(1)) |=> warn_o);

    p_quiet_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == WST_OFF && !start) |=> !rst_req_o);

    p_halt_freezes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == WST_HALT && !ctrl_wr) |=> $stable(cnt_o));
endmodule

bind win_watchdog wwd_checker #(.CNT_W(CNT_W)) u_wwd_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state     (state),
    .tick      (tick),
    .ctrl_wr   (ctrl_wr),
    .start     (start),
    .cnt_o     (cnt_o),
    .warn_o    (warn_o),
    .rst_req_o (rst_req_o)
);

// File: tb/test_win_watchdog.sv
`timescale 1ns/1ps
module test_win_watchdog;
    localparam int BDIV = 4;
    localparam int CW   = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [CW+3:0] wr_data = '0;
    logic          dbg_halt = 1'b0;
    logic [CW-1:0] cnt;
    logic          warn, irq, rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    win_watchdog #(.BASE_DIV(BDIV), .CNT_W(CW)) i_win_watchdog (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .dbg_halt_i (dbg_halt),
        .cnt_o      (cnt),
        .warn_o     (warn),
        .irq_o      (irq),
        .rst_req_o  (rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [CW+3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [CW+3:0] cfgv(input int sel, input bit ie, input bit ds, input int win);
        return {ds, ie, 2'(sel), 7'(win)};
    endfunction

    initial begin
        #1ms;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cnt", cnt, 'h7F);
        chk("R1 warn", warn, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);

        // R8 / R2: OFF state loads, holds, never requests reset
        wr(2'd0, 11'h010);
        chk("R8 no req on bit6=0 while off", rst_req, 0);
        repeat (20) @(negedge clk);
        chk("R2 counter holds while off", cnt, 'h10);
        chk("R8 still quiet", rst_req, 0);

        // R2 start
        wr(2'd0, 11'h0FF);
        chk("R2 start load", cnt, 'h7F);
        chk("R2 no req on start", rst_req, 0);

        // R3 prescaler sweep
        for (int s = 0; s < 4; s++) begin
            wr(2'd1, cfgv(s, 0, 0, 'h7F));
            wr(2'd0, 11'h0FF);
            for (int i = 1; i <= 2 * (BDIV << s); i++) begin
                @(negedge clk);
                chk("R3 decrement period", cnt, 'h7F - i / (BDIV << s));
            end
        end

        // R4/R5 timeout sweep
        for (int s = 0; s < 2; s++) begin
            for (int ie = 0; ie < 2; ie++) begin
                wr(2'd1, cfgv(s, ie[0], 0, 'h7F));
                wr(2'd2, 11'h000);
                wr(2'd0, 11'h0C2);
                for (int i = 1; i <= 3 * (BDIV << s) + 2; i++) begin
                    @(negedge clk);
                    chk("R4 cnt", cnt, 'h42 - i / (BDIV << s));
                    chk("R4 one-cycle req", rst_req, (i == 3 * (BDIV << s)) ? 1 : 0);
                    chk("R5 warn", warn, (i >= 2 * (BDIV << s)) ? 1 : 0);
                    chk("R5 irq gate", irq, (i >= 2 * (BDIV << s) && ie == 1) ? 1 : 0);
                end
            end
        end

        // R9 flag clear behaviour
        wr(2'd2, 11'h001);
        chk("R9 write 1 keeps flag", warn, 1);
        wr(2'd2, 11'h000);
        chk("R9 write 0 clears flag", warn, 0);

        // R6 early refresh sweep
        for (int w = 0; w < 4; w++) begin
            int win;
            win = (w == 0) ? 'h40 : (w == 1) ? 'h55 : (w == 2) ? 'h7E : 'h7F;
            for (int c = 'h40; c <= 'h7F; c++) begin
                wr(2'd1, cfgv(0, 0, 0, 'h7F));
                wr(2'd2, 11'h000);
                wr(2'd0, 11'(8'h80 | c));
                chk("R6 preload quiet", rst_req, 0);
                wr(2'd1, cfgv(0, 0, 0, win));
                wr(2'd0, 11'h0FF);
                chk("R6 early req", rst_req, (c > win) ? 1 : 0);
                chk("R6 early flag", warn, (c > win) ? 1 : 0);
            end
        end
        wr(2'd1, cfgv(0, 0, 0, 'h7F));
        wr(2'd2, 11'h000);

        // R7 bit6 cleared on refresh
        wr(2'd0, 11'h0B0);
        chk("R7 msb clear req", rst_req, 1);
        @(negedge clk);
        chk("R7 pulse ends", rst_req, 0);
        wr(2'd0, 11'h0FF);

        // R2 clearing enable bit is ignored
        wr(2'd0, 11'h07F);
        chk("R2 no req", rst_req, 0);
        repeat (BDIV) @(negedge clk);
        chk("R2 still running", cnt, 'h7E);

        // R10 debug freeze
        wr(2'd1, cfgv(0, 0, 1, 'h7F));
        wr(2'd0, 11'h0FF);
        dbg_halt = 1'b1;
        repeat (2) @(negedge clk);
        held = cnt;
        repeat (20) @(negedge clk);
        chk("R10 frozen", cnt, held);
        dbg_halt = 1'b0;
        @(negedge clk);
        repeat (3 * BDIV) @(negedge clk);
        chk("R10 resume", cnt, held - 3);

        // R10 keep counting when debug-stop is clear
        wr(2'd1, cfgv(0, 0, 0, 'h7F));
        wr(2'd0, 11'h0FF);
        dbg_halt = 1'b1;
        repeat (3 * BDIV) @(negedge clk);
        chk("R10 counts under halt", cnt, 'h7C);
        dbg_halt = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule